// File: doc/BRIEF.md
# Fill and Agitate Phase Sequencer

This block sequences two phases of a washing cycle. A start pulse in the idle state opens the water valve and begins the fill phase. During fill, the block watches a level-reached flag coming from outside the clock domain. When the flag arrives, the block shuts the valve and goes straight into a timed drum-rotation phase.

The rotation phase runs the drum at a programmed speed code for a programmed number of seconds. The seconds come from an internal prescaler. When the time is used up, the rotation phase ends by itself, with no outside event. The block then gives a one-cycle done pulse and returns to idle, ready for the next start.

The duration and the speed code are captured at the start pulse. Changes on those inputs during a run have no effect.

Top module: `wash_phase_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, `valve_o`, `drum_en_o`, `done_o` and `drum_speed_o` are all 0.
- R2: A start pulse sampled in idle sets `valve_o` at that same clock edge. `dur_i` and `speed_i` are captured at that edge. Later changes on them do not affect the current run.
- R3: The level flag passes through a two-flop synchroniser. If the flag rises while `valve_o` is high, `valve_o` falls at the third rising clock edge after the flag was first sampled. `drum_en_o` rises at that same edge.
- R4: If the level flag has already been high for at least three cycles when start arrives, `valve_o` stays high for exactly one cycle.
- R5: With T = `TICKS_PER_SEC` clock cycles per second and a captured duration D, `drum_en_o` stays high for exactly D*T+1 cycles. While it is high, `drum_speed_o` equals the captured speed code. `drum_speed_o` is 0 whenever the drum is off.
- R6: A captured duration of 0 gives a rotation phase of exactly one cycle.
- R7: `done_o` is high for exactly one cycle. That cycle is the one right after the last cycle of `drum_en_o`. The block is then idle: `valve_o` stays low until the next start.
- R8: A start pulse that arrives while the block is not idle is ignored. The rotation length and the return to idle are unchanged.
- R9: `valve_o` and `drum_en_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, acted on only in idle |
| level_ok_i | input | 1 | Water level reached, asynchronous |
| dur_i | input | DUR_W | Rotation time in seconds |
| speed_i | input | SPD_W | Drum speed code |
| valve_o | output | 1 | Water valve open |
| drum_en_o | output | 1 | Drum rotation enable |
| drum_speed_o | output | SPD_W | Speed code for the drum, 0 when idle |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions take three things for granted about the inputs:
- Reset is applied from the start of the run.
- The level flag is a level signal, held for at least a few cycles.
- A new start pulse waits until the previous run has ended.

The bench changes every input only on the falling clock edge, so values are stable at the sampling edge. Before each run it holds the level flag long enough to settle through the synchroniser. It deliberately sends extra start pulses during rotation and changes the duration and speed inputs in mid-run, and then checks that neither has any effect.

// File: rtl/wps_pkg.sv
package wps_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_SPIN = 2'd2
  } phase_t;

  // Remaining-seconds update: step down by one on a tick, saturating at zero.
  function automatic logic [31:0] count_down(input logic [31:0] rem, input logic tick);
    if (tick && rem != 32'd0) return rem - 32'd1;
    return rem;
  endfunction

  // Prescaler wrap test: true on the last cycle of a second.
  function automatic logic at_wrap(input logic [31:0] cnt, input logic [31:0] period);
    return cnt == period - 32'd1;
  endfunction

endpackage

// File: rtl/wps_sync.sv
module wps_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic meta_q, stab_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      stab_q <= 1'b0;
    end else begin
      meta_q <= async_i;
      stab_q <= meta_q;
    end
  end

  assign sync_o = stab_q;
endmodule

// File: rtl/wps_tick.sv
module wps_tick #(
  parameter int unsigned TICKS_PER_SEC = 100_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  generate
    if (TICKS_PER_SEC <= 1) begin : g_every_cycle
      assign tick_o = run_i;
    end else begin : g_divider
      localparam int unsigned CW = $clog2(TICKS_PER_SEC);
      logic [CW-1:0] cnt_q;
      logic          wrap;

      assign wrap   = wps_pkg::at_wrap(32'(cnt_q), 32'(TICKS_PER_SEC));
      assign tick_o = run_i && wrap;

      always_ff @(posedge clk) begin
        if (!rst_n || !run_i) cnt_q <= '0;
        else if (wrap)        cnt_q <= '0;
        else                  cnt_q <= cnt_q + 1'b1;
      end

      // R5: ticks are spaced apart, never back to back
      assert_tick_spaced_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate

  // R5: no tick outside the rotation phase
  assert_tick_only_running_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> run_i);
endmodule

// File: rtl/wps_ctrl.sv
module wps_ctrl #(
  parameter int unsigned DUR_W = 8,
  parameter int unsigned SPD_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             level_s_i,
  input  logic             tick_i,
  input  logic [DUR_W-1:0] dur_i,
  input  logic [SPD_W-1:0] speed_i,
  output logic             spin_o,
  output logic             valve_o,
  output logic             drum_en_o,
  output logic [SPD_W-1:0] drum_speed_o,
  output logic             done_o
);
  import wps_pkg::*;

  phase_t           state_q;
  logic [DUR_W-1:0] dur_q, rem_q;
  logic [SPD_W-1:0] spd_q;
  logic             done_q;

  // Named internal events
  logic start_take, fill_exit, spin_exit;
  assign start_take = (state_q == ST_IDLE) && start_i;
  assign fill_exit  = (state_q == ST_FILL) && level_s_i;
  assign spin_exit  = (state_q == ST_SPIN) && (rem_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dur_q   <= '0;
      rem_q   <= '0;
      spd_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_take) begin
          state_q <= ST_FILL;
          dur_q   <= dur_i;
          spd_q   <= speed_i;
        end
        ST_FILL: if (fill_exit) begin
          state_q <= ST_SPIN;
          rem_q   <= dur_q;
        end
        ST_SPIN: if (spin_exit) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end else begin
          rem_q <= DUR_W'(count_down(32'(rem_q), tick_i));
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign spin_o       = (state_q == ST_SPIN);
  assign valve_o      = (state_q == ST_FILL);
  assign drum_en_o    = spin_o;
  assign drum_speed_o = spin_o ? spd_q : '0;
  assign done_o       = done_q;

  // R9: valve and drum are exclusive
  assert_valve_drum_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(valve_o && drum_en_o));
  // R7: done is a single-cycle pulse
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R7: done follows the end of rotation
  assert_done_after_spin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    spin_exit |=> (done_o && !drum_en_o && !valve_o));
  // R3: a synchronised level closes the valve at the next edge
  assert_valve_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_exit |=> (!valve_o && drum_en_o));
  // R5: remaining time moves only on a tick
  assert_rem_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (spin_o && !spin_exit && !tick_i) |=> $stable(rem_q));
  // R8: a start pulse during rotation does not reopen the valve
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (spin_o && !spin_exit && start_i) |=> !valve_o);
  // R2: captured speed stays fixed while the drum turns
  assert_speed_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (spin_o && !spin_exit) |=> $stable(drum_speed_o));
endmodule

// File: rtl/wash_phase_seq.sv
module wash_phase_seq #(
  parameter int unsigned TICKS_PER_SEC = 100_000_000,
  parameter int unsigned DUR_W         = 8,
  parameter int unsigned SPD_W         = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             level_ok_i,
  input  logic [DUR_W-1:0] dur_i,
  input  logic [SPD_W-1:0] speed_i,
  output logic             valve_o,
  output logic             drum_en_o,
  output logic [SPD_W-1:0] drum_speed_o,
  output logic             done_o
);
  logic level_s, spin, sec_tick;

  wps_sync u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (level_ok_i),
    .sync_o  (level_s)
  );

  wps_tick #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (spin),
    .tick_o (sec_tick)
  );

  wps_ctrl #(.DUR_W(DUR_W), .SPD_W(SPD_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .level_s_i    (level_s),
    .tick_i       (sec_tick),
    .dur_i        (dur_i),
    .speed_i      (speed_i),
    .spin_o       (spin),
    .valve_o      (valve_o),
    .drum_en_o    (drum_en_o),
    .drum_speed_o (drum_speed_o),
    .done_o       (done_o)
  );
endmodule

// File: tb/test_wash_phase_seq.sv
module test_wash_phase_seq;
  localparam int T   = 4;
  localparam int DW  = 4;
  localparam int SW  = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, level = 1'b0;
  logic [DW-1:0] dur = '0;
  logic [SW-1:0] spd = '0;
  logic valve, drum, done;
  logic [SW-1:0] dspd;
  int checks = 0, errors = 0, cycles = 0;

  wash_phase_seq #(.TICKS_PER_SEC(T), .DUR_W(DW), .SPD_W(SW)) i_wash_phase_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .level_ok_i(level),
    .dur_i(dur), .speed_i(spd), .valve_o(valve), .drum_en_o(drum),
    .drum_speed_o(dspd), .done_o(done)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  // One run: d = duration, s = speed, k = negedges before level rises,
  // pre = level already settled high, poke = extra start in rotation.
  task automatic run(input int d, input int s, input int k, input bit pre, input bit poke);
    int vcnt = 0, dcnt = 0, spd_bad = 0, done_pos = -1, last_drum = -1;
    bit poked = 0;
    if (pre) begin
      level = 1'b1;
      repeat (3) @(negedge clk);
    end
    start = 1'b1; dur = DW'(d); spd = SW'(s);
    @(negedge clk);
    start = 1'b0; dur = ~DW'(d); spd = ~SW'(s);   // R2: mid-run changes must not matter
    for (int i = 1; i < 400 && done_pos < 0; i++) begin
      if (valve) vcnt++;
      if (drum) begin
        dcnt++; last_drum = i;
        if (int'(dspd) != s) spd_bad++;
      end else if (dspd != '0) spd_bad++;
      if (done) done_pos = i;
      if (start) start = 1'b0;
      if (!pre && i == k) level = 1'b1;
      if (poke && drum && !poked) begin start = 1'b1; poked = 1; end
      @(negedge clk);
    end
    start = 1'b0;
    check(pre ? "R4 valve cycles" : "R3 valve cycles", vcnt, pre ? 1 : k + 2);
    check(d == 0 ? "R6 drum cycles" : "R5 drum cycles", dcnt, d * T + 1);
    check(poke ? "R8 drum cycles with start" : "R5 speed mismatches", spd_bad + (poke ? dcnt - (d*T+1) : 0), 0);
    check("R7 done position", done_pos, last_drum + 1);
    level = 1'b0;
    for (int j = 0; j < 4; j++) begin
      check("R7 idle after done", {done, valve, drum}, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    @(negedge clk);
    check("R1 reset outputs", {valve, drum, done, dspd}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 first cycle", {valve, drum, done, dspd}, 0);
    @(negedge clk);
    for (int d = 0; d < 16; d++) begin
      run(d, d % 8, 1 + (d % 3), 1'b0, 1'b0);
      run(d, 7 - (d % 8), 2, 1'b1, d[0]);
    end
    run(3, 5, 6, 1'b0, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule